// File: doc/BRIEF.md
# Machine Status Register with Instruction Legality Guard

This block holds the 64-bit machine status word of a simple in-order core and decides, in the decode stage, whether the instruction being decoded may run. The word has seven fields. Two are single-bit privilege flags: the current supervisor flag and the previous-supervisor flag. The others are a global trap enable, a floating-point unit enable, and two wide-addressing enables, one for user mode and one for kernel mode. The last field is an 8-bit interrupt mask. Every other bit is reserved. Reserved bits are dropped on every write and always read back as zero.

The decoder presents a valid strobe and three class flags for the instruction: supervisor-only, floating-point and wide-only. The guard compares them with the stored word and raises at most one trap, with a 2-bit cause code. A write lands on the next clock edge. During the cycle of a write, the guard still judges the instruction against the old value of the word.

Top module: `status_guard`

## Requirements
- R1: While reset is high at a clock edge, the word becomes 0x8, which has only the supervisor flag (bit 3) set. The next read therefore returns 64'h8.
- R2: A write stores only the implemented bits. After the edge, the read port returns wr_data AND 64'hFF7D. Bit 0 is trap enable, bit 2 is previous supervisor, bit 3 is supervisor, bit 4 is FPU enable, bit 5 is user wide, bit 6 is kernel wide, and bits 15:8 are the interrupt mask.
- R3: Bit 1, bit 7 and bits 63:16 always read as zero, whatever has been written to them.
- R4: The read value changes only at the clock edge after a write, or after reset. While no write is made, it holds.
- R5: A valid supervisor-only instruction while bit 3 is 0 gives trap_valid=1 with cause 2'd1 (privileged).
- R6: A valid floating-point instruction while bit 4 is 0 gives trap_valid=1 with cause 2'd2 (FPU disabled), unless R5 also applies.
- R7: The active register width is 64 when bit 3=1 and bit 6=1, or when bit 3=0 and bit 5=1; otherwise it is 32. A valid wide-only instruction while the width is 32 gives cause 2'd3 (illegal), unless R5 or R6 applies.
- R8: When several checks fail, exactly one cause is reported. The priority is privileged, then FPU disabled, then illegal.
- R9: With dec_valid low, or with no check failing, trap_valid is 0 and trap_cause is 2'd0.
- R10: In the cycle of a write, the trap outputs are computed from the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 64 | Value to write; reserved bits are discarded |
| rd_data | output | 64 | Current status word |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_priv | input | 1 | The instruction is supervisor-only |
| dec_fp | input | 1 | The instruction uses the FPU |
| dec_wide | input | 1 | The instruction needs the 64-bit width |
| trap_valid | output | 1 | The instruction must trap |
| trap_cause | output | 2 | 0 none, 1 privileged, 2 FPU disabled, 3 illegal |

## Verification
The bench builds the block with its default parameters: a 64-bit word and a 32-bit narrow width. With these values, each wide-only check turns on the choice between the two wide-addressing bits, which is made by the supervisor flag. Table vectors set the flag each way with each addressing bit. This shows that the addressing bit belonging to the other mode has no effect. They also combine failing checks to exercise the priority order, and write all-ones and reserved-only patterns to exercise the masking. Directed steps then check the reset value, the gating by dec_valid, the use of the old value in a write cycle, and a reset in the middle of a run.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int unsigned STAT_W      = 64;
    localparam int unsigned POS_TRAPEN  = 0;
    localparam int unsigned POS_PREVSUP = 2;
    localparam int unsigned POS_SUP     = 3;
    localparam int unsigned POS_FPUEN   = 4;
    localparam int unsigned POS_UWIDE   = 5;
    localparam int unsigned POS_KWIDE   = 6;
    localparam int unsigned IRQ_LO      = 8;
    localparam int unsigned IRQ_W       = 8;
    localparam int unsigned NUM_CHECKS  = 3;

    typedef struct packed {
        logic [IRQ_W-1:0] irq_mask;
        logic             kern_wide;
        logic             user_wide;
        logic             fpu_en;
        logic             sup;
        logic             prev_sup;
        logic             trap_en;
    } status_t;

    typedef struct packed {
        logic priv;
        logic fp;
        logic wide;
    } insn_class_t;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PRIV    = 2'd1,
        CAUSE_FPOFF   = 2'd2,
        CAUSE_ILLEGAL = 2'd3
    } cause_e;

    localparam status_t RESET_STATE = '{irq_mask: '0, kern_wide: 1'b0,
        user_wide: 1'b0, fpu_en: 1'b0, sup: 1'b1, prev_sup: 1'b0, trap_en: 1'b0};

    function automatic logic [STAT_W-1:0] pack_status(input status_t s);
        logic [STAT_W-1:0] w;
        w = '0;
        w[POS_TRAPEN]             = s.trap_en;
        w[POS_PREVSUP]            = s.prev_sup;
        w[POS_SUP]                = s.sup;
        w[POS_FPUEN]              = s.fpu_en;
        w[POS_UWIDE]              = s.user_wide;
        w[POS_KWIDE]              = s.kern_wide;
        w[IRQ_LO +: IRQ_W]        = s.irq_mask;
        return w;
    endfunction

    function automatic status_t unpack_status(input logic [STAT_W-1:0] w);
        status_t s;
        s.trap_en   = w[POS_TRAPEN];
        s.prev_sup  = w[POS_PREVSUP];
        s.sup       = w[POS_SUP];
        s.fpu_en    = w[POS_FPUEN];
        s.user_wide = w[POS_UWIDE];
        s.kern_wide = w[POS_KWIDE];
        s.irq_mask  = w[IRQ_LO +: IRQ_W];
        return s;
    endfunction

    function automatic logic [STAT_W-1:0] implemented_mask();
        return pack_status('1);
    endfunction

    function automatic cause_e cause_of_check(input int unsigned idx);
        case (idx)
            0:       return CAUSE_PRIV;
            1:       return CAUSE_FPOFF;
            default: return CAUSE_ILLEGAL;
        endcase
    endfunction

endpackage

// File: rtl/status_store.sv
module status_store
    import status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_word,
    output status_t           state_q
);

    status_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = unpack_status(wr_word);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/width_select.sv
module width_select #(
    parameter int unsigned WIDE_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic sup,
    input  logic user_wide,
    input  logic kern_wide,
    output logic is_wide
);

    int unsigned cur_width;

    always_comb begin
        if (sup) begin
            cur_width = kern_wide ? WIDE_W : NARROW_W;
        end else begin
            cur_width = user_wide ? WIDE_W : NARROW_W;
        end
        is_wide = (cur_width == WIDE_W);
    end

endmodule

// File: rtl/legality_check.sv
module legality_check
    import status_pkg::*;
(
    input  logic        dec_valid,
    input  insn_class_t cls,
    input  logic        sup,
    input  logic        fpu_en,
    input  logic        is_wide,
    output logic        trap_valid,
    output cause_e      trap_cause
);

    logic [NUM_CHECKS-1:0] fail;
    logic [NUM_CHECKS-1:0] win;

    always_comb begin
        fail    = '0;
        fail[0] = dec_valid && cls.priv && !sup;
        fail[1] = dec_valid && cls.fp   && !fpu_en;
        fail[2] = dec_valid && cls.wide && !is_wide;
    end

    for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_prio
        if (i == 0) begin : g_top
            assign win[i] = fail[i];
        end else begin : g_rest
            assign win[i] = fail[i] && !(|fail[i-1:0]);
        end
    end

    always_comb begin
        trap_cause = CAUSE_NONE;
        for (int unsigned k = 0; k < NUM_CHECKS; k++) begin
            if (win[k]) begin
                trap_cause = cause_of_check(k);
            end
        end
        trap_valid = |win;
    end

endmodule

// File: rtl/status_guard.sv
module status_guard
    import status_pkg::*;
#(
    parameter int unsigned DATA_W   = STAT_W,
    parameter int unsigned NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dec_valid,
    input  logic              dec_priv,
    input  logic              dec_fp,
    input  logic              dec_wide,
    output logic              trap_valid,
    output logic [1:0]        trap_cause
);

    status_t     state_q;
    insn_class_t cls;
    logic        is_wide;
    cause_e      cause;

    assign cls = '{priv: dec_priv, fp: dec_fp, wide: dec_wide};

    status_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (STAT_W'(wr_data)),
        .state_q (state_q)
    );

    width_select #(
        .WIDE_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_width (
        .sup       (state_q.sup),
        .user_wide (state_q.user_wide),
        .kern_wide (state_q.kern_wide),
        .is_wide   (is_wide)
    );

    legality_check u_check (
        .dec_valid  (dec_valid),
        .cls        (cls),
        .sup        (state_q.sup),
        .fpu_en     (state_q.fpu_en),
        .is_wide    (is_wide),
        .trap_valid (trap_valid),
        .trap_cause (cause)
    );

    assign trap_cause = cause;
    assign rd_data    = DATA_W'(pack_status(state_q));

endmodule

// File: rtl/status_guard_checker.sv
module status_guard_checker
    import status_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [63:0] rd_data,
    input logic        dec_valid,
    input logic        dec_priv,
    input logic        dec_fp,
    input logic        dec_wide,
    input logic        trap_valid,
    input logic [1:0]  trap_cause
);

    localparam logic [63:0] KEEP = 64'hFF7D;

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 64'h8);

    assert_write_masked_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> rd_data == ($past(wr_data) & KEEP));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~KEEP) == 64'h0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(rd_data));

    assert_priv_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_priv && !rd_data[3]) |-> (trap_valid && trap_cause == 2'd1));

    assert_fpoff_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_fp && !rd_data[4] && !(dec_priv && !rd_data[3]))
        |-> (trap_valid && trap_cause == 2'd2));

    assert_illegal_trap_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_wide && !(dec_priv && !rd_data[3]) && !(dec_fp && !rd_data[4])
         && !(rd_data[3] ? rd_data[6] : rd_data[5]))
        |-> (trap_valid && trap_cause == 2'd3));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!trap_valid && trap_cause == 2'd0));

endmodule

bind status_guard status_guard_checker u_status_guard_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .dec_valid  (dec_valid),
    .dec_priv   (dec_priv),
    .dec_fp     (dec_fp),
    .dec_wide   (dec_wide),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause)
);

// File: tb/test_status_guard.sv
module test_status_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        dec_valid = 1'b0;
    logic        dec_priv = 1'b0;
    logic        dec_fp = 1'b0;
    logic        dec_wide = 1'b0;
    logic        trap_valid;
    logic [1:0]  trap_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    status_guard i_status_guard (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .dec_valid  (dec_valid),
        .dec_priv   (dec_priv),
        .dec_fp     (dec_fp),
        .dec_wide   (dec_wide),
        .trap_valid (trap_valid),
        .trap_cause (trap_cause)
    );

    // {write value, class priv/fp/wide, expected trap_valid, expected cause}
    localparam int NVEC = 12;
    localparam logic [69:0] VECS [NVEC] = '{
        {64'h0000_0000_0000_0018, 3'b111, 1'b1, 2'd3},
        {64'h0000_0000_0000_0058, 3'b111, 1'b0, 2'd0},
        {64'h0000_0000_0000_0010, 3'b100, 1'b1, 2'd1},
        {64'h0000_0000_0000_0000, 3'b011, 1'b1, 2'd2},
        {64'h0000_0000_0000_0030, 3'b001, 1'b0, 2'd0},
        {64'h0000_0000_0000_0050, 3'b001, 1'b1, 2'd3},
        {64'h0000_0000_0000_0028, 3'b001, 1'b1, 2'd3},
        {64'h0000_0000_0000_0000, 3'b111, 1'b1, 2'd1},
        {64'hFFFF_FFFF_FFFF_FFFF, 3'b111, 1'b0, 2'd0},
        {64'hFFFF_FFFF_FFFF_0082, 3'b010, 1'b1, 2'd2},
        {64'h0000_0000_0000_0008, 3'b010, 1'b1, 2'd2},
        {64'h0000_0000_0000_0A5C, 3'b001, 1'b0, 2'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic set_class(input logic v, input logic [2:0] c);
        dec_valid = v;
        {dec_priv, dec_fp, dec_wide} = c;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", rd_data, 64'h8);
        set_class(1'b0, 3'b111);
        check("R9 idle trap_valid", {63'b0, trap_valid}, 64'd0);
        check("R9 idle cause", {62'b0, trap_cause}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            set_class(1'b0, 3'b000);
            write_word(VECS[i][69:6]);
            check("R2 R3 masked read", rd_data, VECS[i][69:6] & 64'hFF7D);
            set_class(1'b1, VECS[i][5:3]);
            check("R5 R6 R7 R8 trap_valid", {63'b0, trap_valid}, {63'b0, VECS[i][2]});
            check("R5 R6 R7 R8 trap_cause", {62'b0, trap_cause}, {62'b0, VECS[i][1:0]});
        end

        // R4: no write, value holds across several cycles
        set_class(1'b0, 3'b000);
        write_word(64'h0000_0000_0000_1234);
        repeat (3) @(negedge clk);
        #1;
        check("R4 hold without write", rd_data, 64'h0000_0000_0000_1234 & 64'hFF7D);

        // R10: a write cycle judges against the old value
        write_word(64'h18);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 64'h58;
        set_class(1'b1, 3'b001);
        check("R10 old value cause", {62'b0, trap_cause}, 64'd3);
        check("R4 read before edge", rd_data, 64'h18);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 new value cause", {62'b0, trap_cause}, 64'd0);
        check("R9 no failing check valid", {63'b0, trap_valid}, 64'd0);

        // R9: a failing class with dec_valid low stays quiet
        write_word(64'h0);
        set_class(1'b0, 3'b111);
        check("R9 gated valid", {63'b0, trap_valid}, 64'd0);

        // R1: reset in the middle of a run
        set_class(1'b0, 3'b000);
        write_word(64'hFF7D);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset mid run", rd_data, 64'h8);
        set_class(1'b1, 3'b010);
        check("R6 after reset cause", {62'b0, trap_cause}, 64'd2);

        finish_run();
    end

endmodule